// File: doc/BRIEF.md
# Block-Mode DMA Address Sequencer

This block drives the addressing of one DMA channel that runs in block mode. Software-side logic loads a 24-bit source address, a 24-bit destination address, an 8-bit block length and a 16-bit block count. Each request then moves one whole block. The sequencer presents a source/destination address pair with a transfer strobe, and it advances once for every unit the bus acknowledges. The sequencer itself moves no data.

Either address can count up, count down or stay still. The step is one byte or one 16-bit word. A select input marks one of the two addresses as the block-area pointer. After the last unit of every block, that pointer returns to the value it was loaded with, while the other address carries on. The length counter reloads itself after each block. When the block count is used up, the sequencer gives a one-cycle completion pulse and then refuses requests until a new count is loaded.

Top module: `blk_dma_seq`

## Requirements
- R1: After reset `busy`, `xfer` and `done` are 0, both addresses are 0, and a request is ignored because no block count has been loaded.
- R2: The load inputs write their register only while `busy` is 0. A load pulsed during a block leaves the addresses unchanged. Loading a block count of 0 leaves the channel unable to start.
- R3: Each mode input uses 2'b01 for increment, 2'b10 for decrement, and 2'b00 or 2'b11 for fixed. An address moves once per acknowledged unit, by 2 when `word_sz` is 1 and by 1 otherwise.
- R4: A request that arrives while idle with a count loaded sets `busy` on the next edge. Exactly N units are then strobed, where N is the loaded block length and a length of 0 means 256.
- R5: When `area_is_dst` is 0 the source address is the block-area pointer, and when it is 1 the destination address is. In the cycle after the last unit of a block, the pointer equals its loaded value. The other address has advanced normally.
- R6: The block length counter reloads in the same edge as the last unit. Every later block therefore has the same length N.
- R7: After the last unit of the last block, `done` is 1 for exactly one cycle and `busy` is 0. After each earlier block `done` stays 0.
- R8: A request raised while `busy` is 1 has no effect. After a block ends, the channel stays idle unless a new request arrives.
- R9: After completion, requests are ignored until a block count is loaded again. After that reload a request starts a block.
- R10: While `xfer` is 1 and `ack` is 0, both addresses hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_src | input | 1 | Load source address and its start copy |
| src_in | input | 24 | Source address load value |
| ld_dst | input | 1 | Load destination address and its start copy |
| dst_in | input | 24 | Destination address load value |
| ld_len | input | 1 | Load block length (initial and working counter) |
| len_in | input | 8 | Block length load value |
| ld_cnt | input | 1 | Load block count |
| cnt_in | input | 16 | Block count load value |
| src_mode | input | 2 | Source step mode |
| dst_mode | input | 2 | Destination step mode |
| area_is_dst | input | 1 | 1: destination is block-area pointer; 0: source |
| word_sz | input | 1 | 1: step 2, 0: step 1 |
| req | input | 1 | Block transfer request |
| ack | input | 1 | Current unit accepted by the bus |
| src_addr | output | 24 | Current source address |
| dst_addr | output | 24 | Current destination address |
| xfer | output | 1 | Unit transfer strobe (address pair valid) |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check four things on every cycle. Addresses hold while a strobe stalls. A fixed mode never moves its address. An incrementing address that is not being restored moves by exactly one step. `done` lasts a single cycle and never overlaps `busy`. Other behaviour shows only over whole bench scenarios: the unit count per block, the restore of the block-area pointer, length reload across blocks, the end of the operation, and the ignored requests and loads. The bench checks these against a reference model running random configurations, together with the 256-unit length case and reload after completion.

// File: rtl/blk_dma_seq.sv
module blk_dma_seq #(
  parameter int AW = 24,
  parameter int LW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_src,
  input  logic [AW-1:0] src_in,
  input  logic          ld_dst,
  input  logic [AW-1:0] dst_in,
  input  logic          ld_len,
  input  logic [LW-1:0] len_in,
  input  logic          ld_cnt,
  input  logic [CW-1:0] cnt_in,
  input  logic [1:0]    src_mode,
  input  logic [1:0]    dst_mode,
  input  logic          area_is_dst,
  input  logic          word_sz,
  input  logic          req,
  input  logic          ack,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          xfer,
  output logic          busy,
  output logic          done
);
  localparam logic [1:0] M_INC = 2'b01;
  localparam logic [1:0] M_DEC = 2'b10;

  logic [AW-1:0] src_q, dst_q, src0_q, dst0_q;
  logic [LW-1:0] len0_q, len_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, armed_q, done_q;

  logic [AW-1:0] step;
  logic          unit, last_unit, last_all;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] a, input logic [1:0] m,
                                        input logic [AW-1:0] s);
    case (m)
      M_INC:   adv = a + s;
      M_DEC:   adv = a - s;
      default: adv = a;
    endcase
  endfunction

  assign step      = word_sz ? AW'(2) : AW'(1);
  assign unit      = busy_q & ack;
  assign last_unit = unit & (len_q == LW'(1));
  assign last_all  = last_unit & (cnt_q == CW'(1));

  assign src_addr = src_q;
  assign dst_addr = dst_q;
  assign xfer     = busy_q;
  assign busy     = busy_q;
  assign done     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0; dst_q <= '0; src0_q <= '0; dst0_q <= '0;
      len0_q <= '0; len_q <= '0; cnt_q <= '0;
      busy_q <= 1'b0; armed_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= last_all;
      if (!busy_q) begin
        if (ld_src) begin src_q <= src_in; src0_q <= src_in; end
        if (ld_dst) begin dst_q <= dst_in; dst0_q <= dst_in; end
        if (ld_len) begin len_q <= len_in; len0_q <= len_in; end
        if (ld_cnt) begin cnt_q <= cnt_in; armed_q <= (cnt_in != '0); end
        if (req && armed_q) busy_q <= 1'b1;
      end else if (unit) begin
        src_q <= (last_unit && !area_is_dst) ? src0_q : adv(src_q, src_mode, step);
        dst_q <= (last_unit &&  area_is_dst) ? dst0_q : adv(dst_q, dst_mode, step);
        if (last_unit) begin
          len_q  <= len0_q;
          cnt_q  <= cnt_q - CW'(1);
          busy_q <= 1'b0;
          if (cnt_q == CW'(1)) armed_q <= 1'b0;
        end else begin
          len_q <= len_q - LW'(1);
        end
      end
    end
  end

  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !ack) |=> ($stable(src_addr) && $stable(dst_addr)));

  a_r3_fixed_src: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && ack && (src_mode == 2'b00 || src_mode == 2'b11)) |=> $stable(src_addr));

  a_r3_inc_dst: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && ack && dst_mode == M_INC && !(area_is_dst && len_q == LW'(1)))
      |=> dst_addr == $past(dst_addr) + $past(step));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r4_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req));
endmodule

// File: tb/blk_dma_seq_tb_top.sv
module blk_dma_seq_tb_top;
  logic clk = 0, rst_n = 0;
  logic ld_src = 0, ld_dst = 0, ld_len = 0, ld_cnt = 0;
  logic [23:0] src_in = 0, dst_in = 0;
  logic [7:0]  len_in = 0;
  logic [15:0] cnt_in = 0;
  logic [1:0]  src_mode = 0, dst_mode = 0;
  logic area_is_dst = 0, word_sz = 0, req = 0, ack = 0;
  logic [23:0] src_addr, dst_addr;
  logic xfer, busy, done;

  int checks = 0, errors = 0;
  logic [23:0] m_src, m_dst, m_src0, m_dst0;
  logic [7:0]  m_len0, m_len;
  int unsigned seed = 32'h1357;

  always #2 clk = ~clk;

  blk_dma_seq dut_i (.*);

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [23:0] nxt(input logic [23:0] a, input logic [1:0] m, input logic w);
    logic [23:0] s = w ? 24'd2 : 24'd1;
    if (m == 2'b01) return a + s;
    if (m == 2'b10) return a - s;
    return a;
  endfunction

  task automatic configure(input logic [23:0] s, input logic [23:0] d, input logic [7:0] l,
                           input logic [15:0] c, input logic [1:0] sm, input logic [1:0] dm,
                           input logic ad, input logic w);
    @(negedge clk);
    src_in = s; dst_in = d; len_in = l; cnt_in = c;
    ld_src = 1; ld_dst = 1; ld_len = 1; ld_cnt = 1;
    src_mode = sm; dst_mode = dm; area_is_dst = ad; word_sz = w;
    @(negedge clk);
    ld_src = 0; ld_dst = 0; ld_len = 0; ld_cnt = 0;
    m_src = s; m_dst = d; m_src0 = s; m_dst0 = d; m_len0 = l; m_len = l;
  endtask

  task automatic run_block(input bit is_last);
    int units = 0;
    int expect_units = (m_len0 == 0) ? 256 : int'(m_len0);
    logic prev_ack = 1;
    req = 1;
    @(negedge clk);
    req = 0;
    chk("R4 busy after request", busy, 1);
    while (xfer && units < 400) begin
      ld_src = 0;
      chk(prev_ack ? "R3/R5 src address" : "R10 src held", src_addr, m_src);
      chk(prev_ack ? "R3/R5 dst address" : "R10 dst held", dst_addr, m_dst);
      ack = ($urandom(seed) % 3) != 0;
      req = $urandom(seed) % 2;
      if (!ack && ($urandom(seed) % 2)) begin ld_src = 1; src_in = 24'hABCDEF; end
      if (ack) begin
        units++;
        if (m_len == 8'd1) begin
          m_src = area_is_dst ? nxt(m_src, src_mode, word_sz) : m_src0;
          m_dst = area_is_dst ? m_dst0 : nxt(m_dst, dst_mode, word_sz);
          m_len = m_len0;
        end else begin
          m_src = nxt(m_src, src_mode, word_sz);
          m_dst = nxt(m_dst, dst_mode, word_sz);
          m_len = m_len - 8'd1;
        end
      end
      prev_ack = ack;
      @(negedge clk);
    end
    ld_src = 0; ack = 0; req = 0;
    chk("R4/R6 units per block", units, expect_units);
    chk("R5 src after block (R2 load ignored)", src_addr, m_src);
    chk("R5 dst after block", dst_addr, m_dst);
    chk("R7 done at block end", done, is_last);
    @(negedge clk);
    chk("R7 done one cycle", done, 0);
    chk("R8 idle after block", busy, 0);
  endtask

  task automatic run_op(input logic [23:0] s, input logic [23:0] d, input logic [7:0] l,
                        input logic [15:0] c, input logic [1:0] sm, input logic [1:0] dm,
                        input logic ad, input logic w);
    configure(s, d, l, c, sm, dm, ad, w);
    for (int b = 0; b < c; b++) run_block(b == c - 1);
    req = 1; @(negedge clk); req = 0; @(negedge clk);
    chk("R9 request after done ignored", busy, 0);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy reset", busy, 0);
    chk("R1 done reset", done, 0);
    chk("R1 xfer reset", xfer, 0);
    chk("R1 src reset", src_addr, 0);
    chk("R1 dst reset", dst_addr, 0);
    rst_n = 1;
    @(negedge clk);
    req = 1; @(negedge clk); req = 0; @(negedge clk);
    chk("R1 request without count ignored", busy, 0);

    configure(24'h100, 24'h200, 8'd3, 16'd0, 2'b01, 2'b01, 0, 0);
    req = 1; @(negedge clk); req = 0; @(negedge clk);
    chk("R2 zero count cannot start", busy, 0);

    run_op(24'h001000, 24'h002000, 8'd4, 16'd3, 2'b01, 2'b01, 0, 0);
    run_op(24'h00FFF0, 24'h000010, 8'd3, 16'd2, 2'b10, 2'b01, 1, 1);
    run_op(24'h000000, 24'hFFFFFF, 8'd0, 16'd1, 2'b01, 2'b10, 1, 0);
    run_op(24'h123456, 24'h654321, 8'd1, 16'd3, 2'b00, 2'b11, 0, 1);

    for (int i = 0; i < 8; i++)
      run_op($urandom(seed), $urandom(seed), 8'($urandom(seed) % 6 + 1),
             16'($urandom(seed) % 3 + 1), 2'($urandom(seed)), 2'($urandom(seed)),
             1'($urandom(seed)), 1'($urandom(seed)));

    @(negedge clk);
    cnt_in = 16'd1; ld_cnt = 1; @(negedge clk); ld_cnt = 0;
    m_len = m_len0;
    run_block(1);
    chk("R9 reload re-arms channel", done, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule